// File: doc/BRIEF.md
# Delayed Read Completion Matcher

This block keeps a small table of delayed read transactions waiting on the upstream side. Each slot holds a target address, the memory read command that started it, a valid flag and a data-ready flag. When an upstream initiator repeats a read, the block compares the attempt with every valid slot at once, in the same cycle. It then answers in one of three ways: buffered data can be returned, the initiator must retry, or a new delayed read must be started.

A configuration input sets how strict the comparison is. With aliasing enabled, the three memory read flavours count as one class and only the address has to agree. With aliasing disabled, the command code must also agree. Surrounding logic installs slots through the allocate port and flags returned data through the ready port. The block retires a slot by itself once its data has been handed out. Data storage and bus interfaces sit outside this block.

Top module: `drcMatcher`

## Requirements
- R1: After reset every slot is empty, so any request is answered with enqueue.
- R2: An allocate writes address and command into slot allocIdx, sets it valid and clears its ready flag. In a cycle where allocate, ready marking or retirement hit the same slot, the allocate wins.
- R3: A ready strobe sets the ready flag of slot readyIdx. The flag takes effect from the next cycle.
- R4: Command codes are 0 for plain memory read, 1 for read line and 2 for read multiple. With aliasEn low, a slot matches only when both address and command code are equal.
- R5: With aliasEn high, a valid slot matches on address alone, whatever the two command codes are.
- R6: With aliasEn low, a slot whose address is equal but whose command differs gives no data: the answer is enqueue unless another slot matches.
- R7: A match on a ready slot raises respHit with respIdx set to that slot. The slot is empty from the next cycle on.
- R8: A match on a slot that is not ready raises respRetry with respIdx set to that slot. The slot stays valid.
- R9: A request that matches no valid slot raises respEnqueue.
- R10: When several slots match, the lowest-numbered one is chosen, whether it is ready or not.
- R11: While reqValid is high exactly one of respHit, respRetry and respEnqueue is high. While it is low all three are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| aliasEn | input | 1 | Treat all memory read commands as equivalent |
| allocValid | input | 1 | Install a new delayed read |
| allocIdx | input | IDX_W | Slot to install into |
| allocAddr | input | ADDR_W | Address of the new delayed read |
| allocCmd | input | 2 | Command code of the new delayed read |
| readyValid | input | 1 | Data for a slot has arrived |
| readyIdx | input | IDX_W | Slot whose data arrived |
| reqValid | input | 1 | Upstream read attempt present |
| reqAddr | input | ADDR_W | Address of the attempt |
| reqCmd | input | 2 | Command code of the attempt |
| respHit | output | 1 | Return buffered data for respIdx |
| respRetry | output | 1 | Matching slot not ready; retry |
| respEnqueue | output | 1 | No match; start a new delayed read |
| respIdx | output | IDX_W | Slot chosen on hit or retry |

## Verification
On every cycle the assertions check four things. First, that exactly one answer is given per request and none without one. Second, that a hit only ever names a ready, valid slot. Third, that a hit slot is empty on the next cycle while a retry slot survives. Fourth, that reset leaves the table empty. They cannot show that the right slot was chosen, that the alias setting widens or narrows the comparison correctly, or that allocate takes priority over other updates. Those points come from the bench sweeps, which compare against a table model kept in the bench.

// File: rtl/drcMatchPkg.sv
package drcMatchPkg;
  typedef enum logic [1:0] {
    CMD_MEM_RD   = 2'd0,
    CMD_RD_LINE  = 2'd1,
    CMD_RD_MULTI = 2'd2
  } rdCmd_e;

  typedef struct packed {
    logic retire;
    logic hit;
    logic retry;
    logic enqueue;
  } matchStrobe_t;
endpackage

// File: rtl/drcMatchDatapath.sv
module drcMatchDatapath #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     aliasEn,
  input  logic                     allocValid,
  input  logic [IDX_W-1:0]         allocIdx,
  input  logic [ADDR_W-1:0]        allocAddr,
  input  drcMatchPkg::rdCmd_e      allocCmd,
  input  logic                     readyValid,
  input  logic [IDX_W-1:0]         readyIdx,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  drcMatchPkg::rdCmd_e      reqCmd,
  input  drcMatchPkg::matchStrobe_t strobe,
  input  logic [IDX_W-1:0]         strobeIdx,
  output logic [ENTRIES-1:0]       matchVec,
  output logic [ENTRIES-1:0]       validVec,
  output logic [ENTRIES-1:0]       readyVec
);
  logic [ADDR_W-1:0]   addrQ [ENTRIES];
  drcMatchPkg::rdCmd_e cmdQ  [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : gSlot
    logic addrEq, cmdEq;
    assign addrEq      = (addrQ[i] == reqAddr);
    assign cmdEq       = aliasEn || (cmdQ[i] == reqCmd);
    assign matchVec[i] = validVec[i] && addrEq && cmdEq;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validVec[i] <= 1'b0;
        readyVec[i] <= 1'b0;
        addrQ[i]    <= '0;
        cmdQ[i]     <= drcMatchPkg::CMD_MEM_RD;
      end else begin
        if (strobe.retire && strobeIdx == IDX_W'(i))
          validVec[i] <= 1'b0;
        if (readyValid && readyIdx == IDX_W'(i))
          readyVec[i] <= 1'b1;
        if (allocValid && allocIdx == IDX_W'(i)) begin
          validVec[i] <= 1'b1;
          readyVec[i] <= 1'b0;
          addrQ[i]    <= allocAddr;
          cmdQ[i]     <= allocCmd;
        end
      end
    end
  end
endmodule

// File: rtl/drcMatchControl.sv
module drcMatchControl #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                      reqValid,
  input  logic [ENTRIES-1:0]        matchVec,
  input  logic [ENTRIES-1:0]        readyVec,
  output drcMatchPkg::matchStrobe_t strobe,
  output logic [IDX_W-1:0]          pickIdx
);
  logic anyMatch;

  always_comb begin
    anyMatch = 1'b0;
    pickIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyMatch = 1'b1;
        pickIdx  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.hit     = reqValid && anyMatch && readyVec[pickIdx];
    strobe.retry   = reqValid && anyMatch && !readyVec[pickIdx];
    strobe.enqueue = reqValid && !anyMatch;
    strobe.retire  = strobe.hit;
  end
endmodule

// File: rtl/drcMatcher.sv
module drcMatcher #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aliasEn,
  input  logic              allocValid,
  input  logic [IDX_W-1:0]  allocIdx,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic [1:0]        allocCmd,
  input  logic              readyValid,
  input  logic [IDX_W-1:0]  readyIdx,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqCmd,
  output logic              respHit,
  output logic              respRetry,
  output logic              respEnqueue,
  output logic [IDX_W-1:0]  respIdx
);
  drcMatchPkg::matchStrobe_t strobe;
  logic [ENTRIES-1:0] matchVec, validVec, readyVec;

  drcMatchDatapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) uDatapath (
    .clk(clk), .rstN(rstN), .aliasEn(aliasEn),
    .allocValid(allocValid), .allocIdx(allocIdx), .allocAddr(allocAddr),
    .allocCmd(drcMatchPkg::rdCmd_e'(allocCmd)),
    .readyValid(readyValid), .readyIdx(readyIdx),
    .reqAddr(reqAddr), .reqCmd(drcMatchPkg::rdCmd_e'(reqCmd)),
    .strobe(strobe), .strobeIdx(respIdx),
    .matchVec(matchVec), .validVec(validVec), .readyVec(readyVec)
  );

  drcMatchControl #(.ENTRIES(ENTRIES)) uControl (
    .reqValid(reqValid), .matchVec(matchVec), .readyVec(readyVec),
    .strobe(strobe), .pickIdx(respIdx)
  );

  assign respHit     = strobe.hit;
  assign respRetry   = strobe.retry;
  assign respEnqueue = strobe.enqueue;
endmodule

// File: rtl/drcMatcherChecker.sv
module drcMatcherChecker #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               allocValid,
  input logic [IDX_W-1:0]   allocIdx,
  input logic               respHit,
  input logic               respRetry,
  input logic               respEnqueue,
  input logic [IDX_W-1:0]   respIdx,
  input logic [ENTRIES-1:0] validVec,
  input logic [ENTRIES-1:0] readyVec
);
  a_r11_one_answer: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $countones({respHit, respRetry, respEnqueue}) == 1);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(respHit || respRetry || respEnqueue));

  a_r7_hit_ready: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> (validVec[respIdx] && readyVec[respIdx]));

  a_r8_retry_valid: assert property (@(posedge clk) disable iff (!rstN)
    respRetry |-> (validVec[respIdx] && !readyVec[respIdx]));

  a_r7_retire_next: assert property (@(posedge clk) disable iff (!rstN)
    (respHit && !(allocValid && allocIdx == respIdx)) |=> !validVec[$past(respIdx)]);

  a_r8_retry_keeps: assert property (@(posedge clk) disable iff (!rstN)
    respRetry |=> validVec[$past(respIdx)]);

  a_r1_reset_empty: assert property (@(posedge clk)
    !rstN |=> validVec == '0);
endmodule

bind drcMatcher drcMatcherChecker #(.ENTRIES(ENTRIES)) uChecker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid),
  .allocValid(allocValid), .allocIdx(allocIdx),
  .respHit(respHit), .respRetry(respRetry), .respEnqueue(respEnqueue),
  .respIdx(respIdx), .validVec(validVec), .readyVec(readyVec)
);

// File: tb/drcMatcher_test.sv
module drcMatcher_test;
  localparam int ENTRIES = 4;
  localparam int ADDR_W  = 8;
  localparam int IDX_W   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aliasEn = 1'b0;
  logic allocValid = 1'b0, readyValid = 1'b0, reqValid = 1'b0;
  logic [IDX_W-1:0] allocIdx = '0, readyIdx = '0;
  logic [ADDR_W-1:0] allocAddr = '0, reqAddr = '0;
  logic [1:0] allocCmd = '0, reqCmd = '0;
  logic respHit, respRetry, respEnqueue;
  logic [IDX_W-1:0] respIdx;

  int tests = 0, fails = 0;
  bit done = 0;

  logic mValid [ENTRIES];
  logic mReady [ENTRIES];
  logic [ADDR_W-1:0] mAddr [ENTRIES];
  logic [1:0] mCmd [ENTRIES];

  always #2.5 clk = ~clk;

  drcMatcher #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .aliasEn(aliasEn),
    .allocValid(allocValid), .allocIdx(allocIdx), .allocAddr(allocAddr), .allocCmd(allocCmd),
    .readyValid(readyValid), .readyIdx(readyIdx),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqCmd(reqCmd),
    .respHit(respHit), .respRetry(respRetry), .respEnqueue(respEnqueue), .respIdx(respIdx)
  );

  task automatic clearModel();
    for (int i = 0; i < ENTRIES; i++) begin
      mValid[i] = 0; mReady[i] = 0; mAddr[i] = '0; mCmd[i] = '0;
    end
  endtask

  // Drive one cycle at the falling edge, check the combinational answer, update the model at the rising edge.
  task automatic step(input logic aV, input int aI, input int aA, input int aC,
                      input logic rV, input int rI,
                      input logic qV, input int qA, input int qC, input string tag);
    logic eHit, eRetry, eEnq, found;
    int eIdx;
    allocValid = aV; allocIdx = IDX_W'(aI); allocAddr = ADDR_W'(aA); allocCmd = 2'(aC);
    readyValid = rV; readyIdx = IDX_W'(rI);
    reqValid = qV; reqAddr = ADDR_W'(qA); reqCmd = 2'(qC);
    #1;
    found = 0; eIdx = 0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (mValid[i] && mAddr[i] == ADDR_W'(qA) && (aliasEn || mCmd[i] == 2'(qC))) begin
        found = 1; eIdx = i;
      end
    eHit = qV && found && mReady[eIdx];
    eRetry = qV && found && !mReady[eIdx];
    eEnq = qV && !found;
    tests++;
    if (respHit !== eHit || respRetry !== eRetry || respEnqueue !== eEnq ||
        (found && qV && respIdx !== IDX_W'(eIdx))) begin
      fails++;
      $display("FAIL %s: got hit=%b retry=%b enq=%b idx=%0d, expected hit=%b retry=%b enq=%b idx=%0d",
               tag, respHit, respRetry, respEnqueue, respIdx, eHit, eRetry, eEnq, eIdx);
    end
    @(posedge clk);
    if (eHit) mValid[eIdx] = 0;
    if (rV) mReady[rI] = 1;
    if (aV) begin
      mValid[aI] = 1; mReady[aI] = 0; mAddr[aI] = ADDR_W'(aA); mCmd[aI] = 2'(aC);
    end
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 0;
    allocValid = 0; readyValid = 0; reqValid = 0;
    @(posedge clk); @(posedge clk);
    clearModel();
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int iter;
    clearModel();
    @(negedge clk);
    doReset();

    // R1: empty table after reset, every slot
    for (int k = 0; k < ENTRIES; k++) step(0,0,0,0, 0,0, 1, k, 0, "R1 reset empty");
    step(0,0,0,0, 0,0, 0, 0, 0, "R11 idle quiet");

    // R4 R5 R6 R7 R8 R9: sweep alias, stored cmd, request cmd, slot, readiness
    iter = 0;
    for (int a = 0; a < 2; a++) begin
      aliasEn = a[0];
      for (int sc = 0; sc < 3; sc++)
        for (int rc = 0; rc < 3; rc++)
          for (int s = 0; s < ENTRIES; s++)
            for (int rd = 0; rd < 2; rd++) begin
              step(1, s, iter, sc, 0,0, 0,0,0, "R2 alloc");
              if (rd) step(0,0,0,0, 1, s, 1, iter, rc, "R8 retry before ready");
              step(0,0,0,0, 0,0, 1, iter, rc, a ? "R5 alias match" : (sc == rc ? "R4 strict match" : "R6 cmd differs"));
              step(0,0,0,0, 0,0, 1, iter, rc, "R7 retired after hit");
              step(0,0,0,0, 0,0, 1, 8'hFF, rc, "R9 miss");
              iter++;
            end
    end

    // R10: several slots share an address
    doReset();
    aliasEn = 0;
    for (int s = 1; s < ENTRIES; s++) step(1, s, 8'h5A, 1, 0,0, 0,0,0, "R2 alloc");
    step(0,0,0,0, 1, 2, 1, 8'h5A, 1, "R10 lowest not ready");
    step(0,0,0,0, 1, 1, 1, 8'h5A, 1, "R10 lowest retry");
    step(0,0,0,0, 1, 3, 1, 8'h5A, 1, "R10 lowest ready hit");
    step(0,0,0,0, 0,0, 1, 8'h5A, 1, "R10 next slot hit");
    step(0,0,0,0, 0,0, 1, 8'h5A, 1, "R10 last slot hit");
    step(0,0,0,0, 0,0, 1, 8'h5A, 1, "R7 all retired");

    // R2 R3: allocate wins over ready and retire on the same slot
    step(1, 0, 8'h11, 2, 0,0, 0,0,0, "R2 alloc");
    step(0,0,0,0, 1, 0, 0,0,0, "R3 mark ready");
    step(1, 0, 8'h11, 2, 0,0, 1, 8'h11, 2, "R2 alloc beats retire");
    step(0,0,0,0, 0,0, 1, 8'h11, 2, "R2 re-alloc not ready");
    step(1, 0, 8'h11, 2, 1, 0, 0,0,0, "R2 alloc beats ready");
    step(0,0,0,0, 0,0, 1, 8'h11, 2, "R3 ready cleared by alloc");
    aliasEn = 1;
    step(0,0,0,0, 1, 0, 1, 8'h11, 0, "R5 alias retry");
    step(0,0,0,0, 0,0, 1, 8'h11, 1, "R5 alias hit");

    // R1: reset in the middle of a run empties the table
    step(1, 3, 8'h22, 0, 0,0, 0,0,0, "R2 alloc");
    doReset();
    step(0,0,0,0, 0,0, 1, 8'h22, 0, "R1 reset mid run");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule